// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a 32-bit host write port and a register file whose registers are 128 bits wide. The host can only write one dword at a time, so the block gathers the four dword writes aimed at one wide register in a collector buffer. When the fourth distinct dword has arrived, it hands the register file one atomic 128-bit commit. Any address that does not decode as a wide register passes straight through as a narrow commit and leaves the collector alone.

Registers are page-mapped. The byte address is page × 0x2000 + offset. Normal wide registers occupy offsets below 0x400 in every page. Two 128-bit descriptor-pointer registers sit at offsets 0x830 and 0xA10 in every page, and they follow relaxed rules. A write to their top dword commits immediately. Lower lanes the collector does not hold for that register are filled with zero. A lower-dword write to a descriptor pointer is dropped if the collector is busy with another register. A narrow write to the timer-command dword at offset 0x420 of page 0 also empties the collector.

The register file sees a single-cycle commit pulse one clock after the host write that triggers it. The pulse carries the commit address, the 128-bit data and a wide/narrow flag.

Top module: `wide_wr_collector`

## Requirements
- R1: After synchronous active-high reset no commit is issued, and the collector holds nothing. A descriptor-pointer top-dword write straight after reset commits with bits 95:0 equal to zero.
- R2: A normal wide register (page offset below 0x400; lane = address bits 3:2, register base = address with bits 3:0 cleared) commits only when all four lanes have been written, in any order. Lane i carries the dword written at base + 4·i and sits at data bits 32·i+31:32·i. The commit address is the base, cmt_wide is 1, and the collector is empty afterwards.
- R3: Fewer than four distinct lanes produce no commit. A lane written twice keeps the later value.
- R4: A write to a normal wide register other than the one held discards the held lanes. The next commit carries only the new register's data.
- R5: A write to lane 3 of a descriptor-pointer register (page offset 0x830 or 0xA10, plus 12) always commits that base with cmt_wide = 1. Lanes 0 to 2 come from the collector where it holds them for that same register, and are zero otherwise.
- R6: A lane 0 to 2 write to a descriptor-pointer register is discarded while the collector holds lanes of a different register. The held register's collection continues unchanged. A lane-3 descriptor commit for a different register also leaves the held lanes untouched.
- R7: A write to the dword at page offset 0x420 in page 0 commits narrowly and empties the collector. The same offset in any other page is an ordinary narrow write.
- R8: Any other address commits at once as narrow: cmt_wide = 0, address with bits 1:0 cleared, data in bits 31:0 and bits 127:32 zero. The collector state is not disturbed.
- R9: cmt_valid is high for exactly the one cycle after the host write that triggers a commit, and is low otherwise.
- R10: Decoding uses page = address bits 14:13 and offset = address bits 12:0, so descriptor and wide registers behave identically in every page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host dword write strobe |
| host_addr | input | 15 | Host byte address |
| host_data | input | 32 | Host write data |
| cmt_valid | output | 1 | Commit pulse to the register file |
| cmt_wide | output | 1 | 1 for a 128-bit commit, 0 for a 32-bit commit |
| cmt_addr | output | 15 | Commit byte address (register base or dword address) |
| cmt_data | output | 128 | Commit data |

## Verification
Every commit appears on the port in the cycle right after the host write that triggers it. The bench drives each write at a falling edge and samples the commit port at the next falling edge. It then checks at the following falling edge that the pulse has gone low. A reference model in the bench computes the expected commit, or the absence of one, before every write. A sweep covers all 24 lane orders on several pages, every subset of lower descriptor lanes on every page, and the interleaving, drop, timer-clear and bypass cases.

// File: rtl/wwc_pkg.sv
package wwc_pkg;

    localparam int DWORD_W   = 32;
    localparam int LANES     = 4;
    localparam int LANE_W    = $clog2(LANES);
    localparam int WIDE_W    = DWORD_W * LANES;
    localparam int BLK_SHIFT = LANE_W + 2;

    typedef enum logic [1:0] {
        K_PLAIN  = 2'd0,
        K_WIDE   = 2'd1,
        K_DESC   = 2'd2,
        K_TIMER0 = 2'd3
    } wkind_e;

    typedef logic [LANES-1:0][DWORD_W-1:0] wide_t;

    typedef struct packed {
        wkind_e            kind;
        logic [LANE_W-1:0] lane;
    } dec_t;

    function automatic logic [DWORD_W-1:0] lane_or_zero(
        input logic               keep,
        input logic [DWORD_W-1:0] v
    );
        return keep ? v : '0;
    endfunction

endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
    import wwc_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int PAGE_SHIFT = 13,
    parameter int WIDE_END   = 'h400,
    parameter int DESC_A     = 'h830,
    parameter int DESC_B     = 'hA10,
    parameter int TIMER_OFF  = 'h420
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [ADDR_W-1:0] blk_addr,
    output logic [ADDR_W-1:0] dw_addr
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
    localparam logic [PAGE_SHIFT-1:0] DESC_A_V   = PAGE_SHIFT'(DESC_A);
    localparam logic [PAGE_SHIFT-1:0] DESC_B_V   = PAGE_SHIFT'(DESC_B);
    localparam logic [PAGE_SHIFT-1:0] WIDE_END_V = PAGE_SHIFT'(WIDE_END);
    localparam logic [PAGE_SHIFT-1:0] TIMER_V    = PAGE_SHIFT'(TIMER_OFF);

    logic [PAGE_SHIFT-1:0] off;
    logic [PAGE_SHIFT-1:0] off_blk;
    logic [PAGE_SHIFT-1:0] off_dw;
    logic [PAGE_W-1:0]     page;

    assign off      = addr[PAGE_SHIFT-1:0];
    assign page     = addr[ADDR_W-1:PAGE_SHIFT];
    assign off_blk  = {off[PAGE_SHIFT-1:BLK_SHIFT], {BLK_SHIFT{1'b0}}};
    assign off_dw   = {off[PAGE_SHIFT-1:2], 2'b00};
    assign blk_addr = {addr[ADDR_W-1:BLK_SHIFT], {BLK_SHIFT{1'b0}}};
    assign dw_addr  = {addr[ADDR_W-1:2], 2'b00};

    always_comb begin
        dec.lane = off[BLK_SHIFT-1:2];
        if (off_blk == DESC_A_V || off_blk == DESC_B_V) begin
            dec.kind = K_DESC;
        end else if (off < WIDE_END_V) begin
            dec.kind = K_WIDE;
        end else if (off_dw == TIMER_V && page == '0) begin
            dec.kind = K_TIMER0;
        end else begin
            dec.kind = K_PLAIN;
        end
    end

endmodule

// File: rtl/wwc_collector.sv
module wwc_collector
    import wwc_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  dec_t               dec,
    input  logic [ADDR_W-1:0]  blk_addr,
    input  logic [ADDR_W-1:0]  dw_addr,
    input  logic [DWORD_W-1:0] data,
    output logic               fire,
    output logic               fire_wide,
    output logic [ADDR_W-1:0]  fire_addr,
    output wide_t              fire_data
);
    localparam logic [LANE_W-1:0] TOP = LANE_W'(LANES - 1);

    logic [LANES-1:0]  vld_q, vld_d;
    logic [ADDR_W-1:0] tag_q, tag_d;
    wide_t             buf_q, buf_d;
    wide_t             desc_fill;
    logic              held, hit, foreign;

    assign held    = |vld_q;
    assign hit     = held && (tag_q == blk_addr);
    assign foreign = held && !hit;

    // Descriptor top-dword commit image: held lanes of the same register, else zero.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_fill
            if (g == LANES - 1) begin : g_top
                assign desc_fill[g] = data;
            end else begin : g_low
                assign desc_fill[g] = lane_or_zero(hit && vld_q[g], buf_q[g]);
            end
        end
    endgenerate

    always_comb begin
        vld_d     = vld_q;
        tag_d     = tag_q;
        buf_d     = buf_q;
        fire      = 1'b0;
        fire_wide = 1'b0;
        fire_addr = blk_addr;
        fire_data = '0;
        if (wr) begin
            unique case (dec.kind)
                K_PLAIN, K_TIMER0: begin
                    fire          = 1'b1;
                    fire_addr     = dw_addr;
                    fire_data[0]  = data;
                    if (dec.kind == K_TIMER0) vld_d = '0;
                end
                K_WIDE: begin
                    if (!hit) begin
                        vld_d = '0;
                        tag_d = blk_addr;
                    end
                    buf_d[dec.lane] = data;
                    vld_d[dec.lane] = 1'b1;
                    if (&vld_d) begin
                        fire      = 1'b1;
                        fire_wide = 1'b1;
                        fire_data = buf_d;
                        vld_d     = '0;
                    end
                end
                K_DESC: begin
                    if (dec.lane == TOP) begin
                        fire      = 1'b1;
                        fire_wide = 1'b1;
                        fire_data = desc_fill;
                        if (hit) vld_d = '0;
                    end else if (!foreign) begin
                        if (!hit) begin
                            vld_d = '0;
                            tag_d = blk_addr;
                        end
                        buf_d[dec.lane] = data;
                        vld_d[dec.lane] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            tag_q <= '0;
            buf_q <= '0;
        end else begin
            vld_q <= vld_d;
            tag_q <= tag_d;
            buf_q <= buf_d;
        end
    end

    // R7: page-0 timer write leaves the collector empty
    p_timer_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.kind == K_TIMER0) |=> (vld_q == '0));

    // R8: narrow bypass writes leave collector state untouched
    p_plain_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.kind == K_PLAIN) |=> ($stable(vld_q) && $stable(tag_q) && $stable(buf_q)));

    // R6: dropped descriptor lower-lane write changes nothing
    p_desc_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.kind == K_DESC && dec.lane != TOP && foreign)
        |=> ($stable(vld_q) && $stable(tag_q) && $stable(buf_q)));

    // R2: a completed wide register empties the collector
    p_full_empties_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.kind == K_WIDE && fire) |=> (vld_q == '0));

endmodule

// File: rtl/wwc_commit_reg.sv
module wwc_commit_reg
    import wwc_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              fire_wide,
    input  logic [ADDR_W-1:0] fire_addr,
    input  wide_t             fire_data,
    output logic              cmt_valid,
    output logic              cmt_wide,
    output logic [ADDR_W-1:0] cmt_addr,
    output logic [WIDE_W-1:0] cmt_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmt_valid <= 1'b0;
            cmt_wide  <= 1'b0;
            cmt_addr  <= '0;
            cmt_data  <= '0;
        end else begin
            cmt_valid <= fire;
            if (fire) begin
                cmt_wide <= fire_wide;
                cmt_addr <= fire_addr;
                cmt_data <= fire_data;
            end
        end
    end

endmodule

// File: rtl/wide_wr_collector.sv
module wide_wr_collector
    import wwc_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int PAGE_SHIFT = 13,
    parameter int WIDE_END   = 'h400,
    parameter int DESC_A     = 'h830,
    parameter int DESC_B     = 'hA10,
    parameter int TIMER_OFF  = 'h420
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DWORD_W-1:0]  host_data,
    output logic                cmt_valid,
    output logic                cmt_wide,
    output logic [ADDR_W-1:0]   cmt_addr,
    output logic [WIDE_W-1:0]   cmt_data
);
    dec_t              dec;
    logic [ADDR_W-1:0] blk_addr;
    logic [ADDR_W-1:0] dw_addr;
    logic              fire;
    logic              fire_wide;
    logic [ADDR_W-1:0] fire_addr;
    wide_t             fire_data;

    wwc_decode #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .WIDE_END  (WIDE_END),
        .DESC_A    (DESC_A),
        .DESC_B    (DESC_B),
        .TIMER_OFF (TIMER_OFF)
    ) u_decode (
        .addr    (host_addr),
        .dec     (dec),
        .blk_addr(blk_addr),
        .dw_addr (dw_addr)
    );

    wwc_collector #(.ADDR_W(ADDR_W)) u_collector (
        .clk      (clk),
        .rst      (rst),
        .wr       (host_wr),
        .dec      (dec),
        .blk_addr (blk_addr),
        .dw_addr  (dw_addr),
        .data     (host_data),
        .fire     (fire),
        .fire_wide(fire_wide),
        .fire_addr(fire_addr),
        .fire_data(fire_data)
    );

    wwc_commit_reg #(.ADDR_W(ADDR_W)) u_commit (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .fire_wide(fire_wide),
        .fire_addr(fire_addr),
        .fire_data(fire_data),
        .cmt_valid(cmt_valid),
        .cmt_wide (cmt_wide),
        .cmt_addr (cmt_addr),
        .cmt_data (cmt_data)
    );

    // R1: no commit in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cmt_valid);

    // R9: a commit pulse always follows a host write
    p_commit_after_write_r9: assert property (@(posedge clk) disable iff (rst)
        cmt_valid |-> $past(host_wr));

    // R5: descriptor top-dword write always commits wide
    p_desc_top_commits_r5: assert property (@(posedge clk) disable iff (rst)
        (host_wr && dec.kind == K_DESC && dec.lane == LANE_W'(LANES - 1))
        |=> (cmt_valid && cmt_wide));

    // R8: narrow commits carry nothing above the low dword
    p_narrow_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && !cmt_wide) |-> (cmt_data[WIDE_W-1:DWORD_W] == '0));

endmodule

// File: tb/wide_wr_collector_tb.sv
module wide_wr_collector_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         host_wr = 1'b0;
    logic [14:0]  host_addr = '0;
    logic [31:0]  host_data = '0;
    logic         cmt_valid;
    logic         cmt_wide;
    logic [14:0]  cmt_addr;
    logic [127:0] cmt_data;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [3:0]  m_vld = '0;
    logic [14:0] m_tag = '0;
    logic [31:0] m_ln [4];

    always #5 clk = ~clk;

    wide_wr_collector u_dut (
        .clk      (clk),
        .rst      (rst),
        .host_wr  (host_wr),
        .host_addr(host_addr),
        .host_data(host_data),
        .cmt_valid(cmt_valid),
        .cmt_wide (cmt_wide),
        .cmt_addr (cmt_addr),
        .cmt_data (cmt_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [14:0] a, input logic [31:0] d,
                         output logic ev, output logic ew,
                         output logic [14:0] ea, output logic [127:0] ed);
        int page;
        int off;
        int blk;
        int ln;
        logic [14:0] base;
        bit held;
        bit same;
        page = int'(a) / 'h2000;
        off  = int'(a) % 'h2000;
        blk  = off - (off % 16);
        ln   = (off % 16) / 4;
        base = a - 15'(int'(a) % 16);
        held = (m_vld != 0);
        same = held && (m_tag == base);
        ev = 0; ew = 0; ea = '0; ed = '0;
        if (blk == 'h830 || blk == 'hA10) begin
            if (ln == 3) begin
                ev = 1; ew = 1; ea = base;
                for (int i = 0; i < 3; i++)
                    ed[i*32 +: 32] = (same && m_vld[i]) ? m_ln[i] : 32'h0;
                ed[127:96] = d;
                if (same) m_vld = '0;
            end else if (!held || same) begin
                if (!same) m_vld = '0;
                m_tag = base; m_ln[ln] = d; m_vld[ln] = 1'b1;
            end
        end else if (off < 'h400) begin
            if (!same) m_vld = '0;
            m_tag = base; m_ln[ln] = d; m_vld[ln] = 1'b1;
            if (m_vld == 4'hF) begin
                ev = 1; ew = 1; ea = base;
                ed = {m_ln[3], m_ln[2], m_ln[1], m_ln[0]};
                m_vld = '0;
            end
        end else begin
            ev = 1; ew = 0; ea = a - 15'(int'(a) % 4); ed = {96'h0, d};
            if (page == 0 && (off - off % 4) == 'h420) m_vld = '0;
        end
    endtask

    // one host write; commit due at the next falling edge, gone one cycle later
    task automatic hw(input logic [14:0] a, input logic [31:0] d, input string req);
        logic ev, ew;
        logic [14:0] ea;
        logic [127:0] ed;
        model(a, d, ev, ew, ea, ed);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
        chk(cmt_valid === ev, req, "cmt_valid", 128'(cmt_valid), 128'(ev));
        if (ev) begin
            chk(cmt_wide === ew, req, "cmt_wide", 128'(cmt_wide), 128'(ew));
            chk(cmt_addr === ea, req, "cmt_addr", 128'(cmt_addr), 128'(ea));
            chk(cmt_data === ed, req, "cmt_data", cmt_data, ed);
        end
        @(negedge clk);
        chk(cmt_valid === 1'b0, "R9", "pulse width", 128'(cmt_valid), 128'(0));
    endtask

    function automatic logic [31:0] pat(input int r, input int l, input int s);
        return 32'(32'h5A00_0000 + r * 256 + l * 17 + s * 4099);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seq;
        seq = 0;
        repeat (3) @(negedge clk);
        chk(cmt_valid === 1'b0, "R1", "valid in reset", 128'(cmt_valid), 128'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(cmt_valid === 1'b0, "R1", "valid after reset", 128'(cmt_valid), 128'(0));
        // R1/R5: descriptor top straight after reset has zero low lanes
        hw(15'h083C, 32'hCAFE_0001, "R1");

        // R2 / R10: every lane order on several pages
        begin
            logic [14:0] regs [4];
            regs[0] = 15'h0000; regs[1] = 15'h03F0; regs[2] = 15'h2100; regs[3] = 15'h6200;
            for (int r = 0; r < 4; r++)
                for (int a0 = 0; a0 < 4; a0++)
                    for (int a1 = 0; a1 < 4; a1++)
                        for (int a2 = 0; a2 < 4; a2++)
                            for (int a3 = 0; a3 < 4; a3++)
                                if (a0 != a1 && a0 != a2 && a0 != a3 &&
                                    a1 != a2 && a1 != a3 && a2 != a3) begin
                                    seq++;
                                    hw(regs[r] + 15'(a0 * 4), pat(r, a0, seq), "R2");
                                    hw(regs[r] + 15'(a1 * 4), pat(r, a1, seq), "R2");
                                    hw(regs[r] + 15'(a2 * 4), pat(r, a2, seq), "R2");
                                    hw(regs[r] + 15'(a3 * 4), pat(r, a3, seq), "R10");
                                end
        end

        // R3: partial set, then a rewrite, then completion
        hw(15'h0040, 32'h1111_0000, "R3");
        hw(15'h0044, 32'h1111_0001, "R3");
        hw(15'h0048, 32'h1111_0002, "R3");
        hw(15'h0044, 32'h2222_0001, "R3");
        hw(15'h004C, 32'h1111_0003, "R3");

        // R4: interleaving another wide register drops the first
        hw(15'h0100, 32'hA000_0000, "R4");
        hw(15'h0104, 32'hA000_0001, "R4");
        hw(15'h0200, 32'hB000_0000, "R4");
        hw(15'h0204, 32'hB000_0001, "R4");
        hw(15'h0208, 32'hB000_0002, "R4");
        hw(15'h020C, 32'hB000_0003, "R4");
        hw(15'h0108, 32'hA000_0002, "R4");
        hw(15'h010C, 32'hA000_0003, "R4");
        hw(15'h0100, 32'hA000_0010, "R4");
        hw(15'h0104, 32'hA000_0011, "R4");

        // R5: every subset of lower descriptor lanes, both registers, every page
        for (int pg = 0; pg < 4; pg++)
            for (int dr = 0; dr < 2; dr++)
                for (int m = 0; m < 8; m++) begin
                    logic [14:0] b;
                    b = 15'(pg * 'h2000 + (dr == 0 ? 'h830 : 'hA10));
                    for (int l = 0; l < 3; l++)
                        if (m[l]) hw(b + 15'(l * 4), pat(pg, l, m + dr * 8), "R5");
                    hw(b + 15'd12, pat(pg, 3, m), "R5");
                end

        // R6: descriptor lower write while another register is held
        hw(15'h0300, 32'hC000_0000, "R6");
        hw(15'h0304, 32'hC000_0001, "R6");
        hw(15'h2A14, 32'hDEAD_0001, "R6");
        hw(15'h0834, 32'hDEAD_0002, "R6");
        hw(15'h2A1C, 32'hDEAD_0003, "R6");
        hw(15'h0308, 32'hC000_0002, "R6");
        hw(15'h030C, 32'hC000_0003, "R6");

        // R7: timer command on page 0 clears, on page 1 does not
        hw(15'h0010, 32'hE000_0000, "R7");
        hw(15'h0014, 32'hE000_0001, "R7");
        hw(15'h0018, 32'hE000_0002, "R7");
        hw(15'h0420, 32'h7133_0000, "R7");
        hw(15'h001C, 32'hE000_0003, "R7");
        hw(15'h0010, 32'hE100_0000, "R7");
        hw(15'h0014, 32'hE100_0001, "R7");
        hw(15'h0018, 32'hE100_0002, "R7");
        hw(15'h2420, 32'h7133_0001, "R7");
        hw(15'h001C, 32'hE100_0003, "R7");
        hw(15'h0830, 32'hF000_0000, "R7");
        hw(15'h0423, 32'h7133_0002, "R7");
        hw(15'h083C, 32'hF000_0003, "R7");

        // R8: narrow bypass in the middle of a collection
        hw(15'h0020, 32'h8000_0000, "R8");
        hw(15'h0500, 32'h8888_0001, "R8");
        hw(15'h0024, 32'h8000_0001, "R8");
        hw(15'h1FFE, 32'h8888_0002, "R8");
        hw(15'h0028, 32'h8000_0002, "R8");
        hw(15'h2424, 32'h8888_0003, "R8");
        hw(15'h7000, 32'h8888_0004, "R8");
        hw(15'h002C, 32'h8000_0003, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule